// File: doc/BRIEF.md
# Front-end run-control sequencer

This block steps a detector front-end board through its run lifecycle. It takes commands that a separate decoder has already pulled off the reset/control link. For each run state it chooses what the uplink to the switching layer carries. The choices are slow-control words only, slow control mixed with live hit data, slow control mixed with leftover hit data, a bit-error-rate test pattern, a timing-measurement pattern, or nothing. Two one-shot marker pulses go with the lifecycle. One marks the first cycle of run preparation. The other marks the end of draining when the run terminates.

Commands enter on a valid/ready port with a 32-bit argument. The argument carries the run number with the run-preparation command. A command is consumed on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` goes low only during the single cycle in which a marker pulse is driven. The sender must then keep `cmd_valid`, `cmd_code` and `cmd_arg` steady until `cmd_ready` returns. A consumed command that is not allowed in the current state leaves the state as it is and raises a one-cycle error flag.

State codes: 0 idle, 1 prepare, 2 sync, 3 running, 4 terminating, 5 link test, 6 timing test, 7 held in reset, 8 out of acquisition. Source codes: 0 nothing, 1 slow control, 2 slow control plus hits, 3 slow control plus leftover hits, 4 bit-error-rate pattern, 5 timing pattern.

Top module: `fe_run_sequencer`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, the outputs are: `run_state`=0, `src_sel`=1, both marker pulses low, `cmd_err` low, `cmd_ready` high and `run_number`=0.
- R2: The run path uses these command codes: prepare (1) moves idle to 1, sync (2) moves 1 to 2, start (3) moves 2 to 3, end (4) moves 3 to 4. The new state shows in the cycle after the command is consumed.
- R3: `mark_active` is high for exactly one cycle, the first cycle in state 1, and `cmd_ready` is low in that cycle.
- R4: `src_sel` follows the state: 0 and 8 give 1, 1 gives 1, 2 and 7 give 0, 3 gives 2, 4 gives 3 while draining and 1 in its marker cycle, 5 gives 4, 6 gives 5.
- R5: In state 4, `drain_done` high produces one `mark_tail` pulse in the next cycle. The state stays 4 for that cycle and becomes 0 one cycle later.
- R6: Abort (5) moves states 1, 2, 3 and 4 to idle. If abort is consumed in the same cycle that `drain_done` is high in state 4, abort wins and no `mark_tail` pulse follows.
- R7: Link-test start (6) and timing-test start (8) are allowed only from idle and enter 5 and 6. Link-test stop (7) leaves 5 and timing-test stop (9) leaves 6, both to idle.
- R8: Reset (10) enters state 7 from any other state, and reset-release (11) returns 7 to idle. Disable (13) moves idle to 8, and enable (12) returns 8 to idle.
- R9: A consumed command that is not allowed in the current state leaves the state unchanged and sets `cmd_err` for exactly the next cycle. Codes 0, 14 and 15 are never allowed.
- R10: While `cmd_ready` is low, a presented command is not consumed and raises no error. It is consumed once `cmd_ready` is high again.
- R11: `run_number` takes `cmd_arg` when a prepare command is accepted and keeps that value through every other command and cycle.
- R12: `drain_done` has no effect outside state 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A decoded command is presented |
| cmd_ready | output | 1 | The sequencer can consume a command this cycle |
| cmd_code | input | 4 | Decoded command code |
| cmd_arg | input | RUN_W | Command argument (run number for prepare) |
| drain_done | input | 1 | Leftover hit data has been fully sent |
| run_state | output | 4 | Current run state code |
| src_sel | output | 3 | Uplink source select code |
| mark_active | output | 1 | One-cycle run-active marker pulse |
| mark_tail | output | 1 | One-cycle run-tail marker pulse |
| cmd_err | output | 1 | One-cycle flag for an illegal consumed command |
| run_number | output | RUN_W | Run number latched at prepare |

## Verification
Two events can meet in one cycle in the terminating state: the end of draining, and an abort or reset command. The bench raises `drain_done` and presents an abort in the same cycle. It then expects idle on the next cycle and no tail pulse on that cycle or the one after. A second collision lands a command while a marker cycle holds `cmd_ready` low. The bench expects the command to stay unconsumed and raise no error, then to take effect exactly one cycle later.

// File: rtl/fe_rc_pkg.sv
package fe_rc_pkg;
  localparam int unsigned ST_W  = 4;
  localparam int unsigned CMD_W = 4;
  localparam int unsigned SRC_W = 3;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE  = 4'd0,
    ST_PREP  = 4'd1,
    ST_SYNC  = 4'd2,
    ST_RUN   = 4'd3,
    ST_TERM  = 4'd4,
    ST_LINKT = 4'd5,
    ST_TIMET = 4'd6,
    ST_RST   = 4'd7,
    ST_OOD   = 4'd8
  } rc_state_e;

  typedef enum logic [CMD_W-1:0] {
    C_NONE    = 4'd0,
    C_PREP    = 4'd1,
    C_SYNC    = 4'd2,
    C_START   = 4'd3,
    C_END     = 4'd4,
    C_ABORT   = 4'd5,
    C_LSTART  = 4'd6,
    C_LSTOP   = 4'd7,
    C_TSTART  = 4'd8,
    C_TSTOP   = 4'd9,
    C_RESET   = 4'd10,
    C_RSTOP   = 4'd11,
    C_ENABLE  = 4'd12,
    C_DISABLE = 4'd13
  } rc_cmd_e;

  typedef enum logic [SRC_W-1:0] {
    SRC_NONE   = 3'd0,
    SRC_SC     = 3'd1,
    SRC_SC_HIT = 3'd2,
    SRC_SC_OLD = 3'd3,
    SRC_BERT   = 3'd4,
    SRC_TIMING = 3'd5
  } rc_src_e;
endpackage

// File: rtl/fe_rc_transition.sv
module fe_rc_transition
  import fe_rc_pkg::*;
(
  input  rc_state_e             cur,
  input  logic [CMD_W-1:0]      code,
  output logic                  legal,
  output rc_state_e             nxt
);
  rc_cmd_e cmd;
  logic    in_run;

  always_comb begin
    cmd    = rc_cmd_e'(code);
    in_run = (cur == ST_PREP) || (cur == ST_SYNC) ||
             (cur == ST_RUN)  || (cur == ST_TERM);
    legal  = 1'b0;
    nxt    = cur;
    case (cmd)
      C_PREP:    if (cur == ST_IDLE)  begin legal = 1'b1; nxt = ST_PREP;  end
      C_SYNC:    if (cur == ST_PREP)  begin legal = 1'b1; nxt = ST_SYNC;  end
      C_START:   if (cur == ST_SYNC)  begin legal = 1'b1; nxt = ST_RUN;   end
      C_END:     if (cur == ST_RUN)   begin legal = 1'b1; nxt = ST_TERM;  end
      C_ABORT:   if (in_run)          begin legal = 1'b1; nxt = ST_IDLE;  end
      C_LSTART:  if (cur == ST_IDLE)  begin legal = 1'b1; nxt = ST_LINKT; end
      C_LSTOP:   if (cur == ST_LINKT) begin legal = 1'b1; nxt = ST_IDLE;  end
      C_TSTART:  if (cur == ST_IDLE)  begin legal = 1'b1; nxt = ST_TIMET; end
      C_TSTOP:   if (cur == ST_TIMET) begin legal = 1'b1; nxt = ST_IDLE;  end
      C_RESET:   if (cur != ST_RST)   begin legal = 1'b1; nxt = ST_RST;   end
      C_RSTOP:   if (cur == ST_RST)   begin legal = 1'b1; nxt = ST_IDLE;  end
      C_ENABLE:  if (cur == ST_OOD)   begin legal = 1'b1; nxt = ST_IDLE;  end
      C_DISABLE: if (cur == ST_IDLE)  begin legal = 1'b1; nxt = ST_OOD;   end
      default: begin legal = 1'b0; nxt = cur; end
    endcase
  end
endmodule

// File: rtl/fe_rc_src_map.sv
module fe_rc_src_map
  import fe_rc_pkg::*;
(
  input  rc_state_e cur,
  input  logic      tail_cycle,
  output rc_src_e   src
);
  always_comb begin
    case (cur)
      ST_IDLE, ST_PREP, ST_OOD: src = SRC_SC;
      ST_SYNC, ST_RST:          src = SRC_NONE;
      ST_RUN:                   src = SRC_SC_HIT;
      ST_TERM:                  src = tail_cycle ? SRC_SC : SRC_SC_OLD;
      ST_LINKT:                 src = SRC_BERT;
      ST_TIMET:                 src = SRC_TIMING;
      default:                  src = SRC_NONE;
    endcase
  end
endmodule

// File: rtl/fe_rc_marker.sv
module fe_rc_marker
  import fe_rc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enter_prep,
  input  logic      tail_fire,
  input  rc_state_e cur,
  output logic      act_pulse,
  output logic      tail_pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_pulse  <= 1'b0;
      tail_pulse <= 1'b0;
    end else begin
      act_pulse  <= enter_prep;
      tail_pulse <= tail_fire;
    end
  end

  // R3
  active_first_prep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_pulse |-> (cur == ST_PREP) && ($past(cur) != ST_PREP));

  // R3
  active_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_pulse |=> !act_pulse);

  // R5
  tail_in_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tail_pulse |-> (cur == ST_TERM) && ($past(cur) == ST_TERM));

  // R5
  tail_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tail_pulse |=> (cur == ST_IDLE) && !tail_pulse);
endmodule

// File: rtl/fe_run_sequencer.sv
module fe_run_sequencer
  import fe_rc_pkg::*;
#(
  parameter int unsigned RUN_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [CMD_W-1:0]     cmd_code,
  input  logic [RUN_W-1:0]     cmd_arg,
  input  logic                 drain_done,
  output logic [ST_W-1:0]      run_state,
  output logic [SRC_W-1:0]     src_sel,
  output logic                 mark_active,
  output logic                 mark_tail,
  output logic                 cmd_err,
  output logic [RUN_W-1:0]     run_number
);
  rc_state_e        st_q;
  rc_state_e        st_nxt;
  rc_src_e          src;
  logic             legal;
  logic             accept;
  logic             take;
  logic             tail_fire;
  logic             enter_prep;
  logic             err_q;
  logic [RUN_W-1:0] run_q;

  fe_rc_transition u_trans (
    .cur   (st_q),
    .code  (cmd_code),
    .legal (legal),
    .nxt   (st_nxt)
  );

  assign cmd_ready  = !mark_active && !mark_tail;
  assign accept     = cmd_valid && cmd_ready;
  assign take       = accept && legal;
  assign enter_prep = take && (st_nxt == ST_PREP);
  assign tail_fire  = (st_q == ST_TERM) && !mark_tail && drain_done && !take;

  fe_rc_marker u_mark (
    .clk        (clk),
    .rst_n      (rst_n),
    .enter_prep (enter_prep),
    .tail_fire  (tail_fire),
    .cur        (st_q),
    .act_pulse  (mark_active),
    .tail_pulse (mark_tail)
  );

  fe_rc_src_map u_src (
    .cur        (st_q),
    .tail_cycle (mark_tail),
    .src        (src)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      err_q <= 1'b0;
      run_q <= '0;
    end else begin
      err_q <= accept && !legal;
      if (take) begin
        st_q <= st_nxt;
      end else if (mark_tail) begin
        st_q <= ST_IDLE;
      end
      if (take && (rc_cmd_e'(cmd_code) == C_PREP)) begin
        run_q <= cmd_arg;
      end
    end
  end

  assign run_state  = st_q;
  assign src_sel    = src;
  assign cmd_err    = err_q;
  assign run_number = run_q;

  // R9
  err_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> (st_q == $past(st_q)));

  // R10
  stall_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> !cmd_err);

  // R11
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_q == ST_PREP && $past(st_q) == ST_IDLE) |-> $stable(run_number));

  // R2
  run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == ST_RUN) |-> ($past(st_q) == ST_SYNC));
endmodule

// File: tb/fe_run_sequencer_tb_top.sv
module fe_run_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_code = 4'd0;
  logic [31:0] cmd_arg = 32'd0;
  logic        drain_done = 1'b0;
  logic [3:0]  run_state;
  logic [2:0]  src_sel;
  logic        mark_active;
  logic        mark_tail;
  logic        cmd_err;
  logic [31:0] run_number;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  fe_run_sequencer #(.RUN_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code), .cmd_arg(cmd_arg), .drain_done(drain_done),
    .run_state(run_state), .src_sel(src_sel), .mark_active(mark_active),
    .mark_tail(mark_tail), .cmd_err(cmd_err), .run_number(run_number)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {valid, code, drain, exp_state, exp_src, exp_err}
  localparam int NV = 21;
  localparam logic [13:0] VEC [NV] = '{
    {1'b1, 4'd1,  1'b0, 4'd1, 3'd1, 1'b0},  // R2 prepare
    {1'b1, 4'd3,  1'b0, 4'd1, 3'd1, 1'b1},  // R9 start in prepare
    {1'b1, 4'd2,  1'b0, 4'd2, 3'd0, 1'b0},  // R2 R4 sync
    {1'b1, 4'd3,  1'b0, 4'd3, 3'd2, 1'b0},  // R2 R4 running
    {1'b0, 4'd0,  1'b1, 4'd3, 3'd2, 1'b0},  // R12 drain in running
    {1'b1, 4'd4,  1'b0, 4'd4, 3'd3, 1'b0},  // R2 R4 terminating
    {1'b0, 4'd0,  1'b1, 4'd4, 3'd1, 1'b0},  // R5 tail cycle
    {1'b0, 4'd0,  1'b0, 4'd0, 3'd1, 1'b0},  // R5 back to idle
    {1'b1, 4'd6,  1'b0, 4'd5, 3'd4, 1'b0},  // R7 link test
    {1'b1, 4'd1,  1'b0, 4'd5, 3'd4, 1'b1},  // R7 R9 prepare refused
    {1'b1, 4'd7,  1'b0, 4'd0, 3'd1, 1'b0},  // R7
    {1'b1, 4'd8,  1'b0, 4'd6, 3'd5, 1'b0},  // R7 timing test
    {1'b1, 4'd9,  1'b0, 4'd0, 3'd1, 1'b0},  // R7
    {1'b1, 4'd13, 1'b0, 4'd8, 3'd1, 1'b0},  // R8 disable
    {1'b1, 4'd1,  1'b0, 4'd8, 3'd1, 1'b1},  // R8 R9
    {1'b1, 4'd12, 1'b0, 4'd0, 3'd1, 1'b0},  // R8 enable
    {1'b1, 4'd10, 1'b0, 4'd7, 3'd0, 1'b0},  // R8 reset
    {1'b1, 4'd15, 1'b0, 4'd7, 3'd0, 1'b1},  // R9 code 15
    {1'b1, 4'd11, 1'b0, 4'd0, 3'd1, 1'b0},  // R8 release
    {1'b1, 4'd0,  1'b0, 4'd0, 3'd1, 1'b1},  // R9 code 0
    {1'b1, 4'd5,  1'b0, 4'd0, 3'd1, 1'b1}   // R9 abort in idle
  };

  task automatic step(input logic v, input logic [3:0] c, input logic d);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = v; cmd_code = c; drain_done = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_code = 4'd0; drain_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 state in reset", run_state, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 state", run_state, 0);
    chk("R1 src", src_sel, 1);
    chk("R1 markers", {mark_active, mark_tail, cmd_err}, 0);
    chk("R1 ready", cmd_ready, 1);
    chk("R1 run number", run_number, 0);

    cmd_arg = 32'hA5A5_0001;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][13], VEC[i][12:9], VEC[i][8]);
      chk($sformatf("R4 vector %0d state", i), run_state, VEC[i][7:4]);
      chk($sformatf("R4 vector %0d src", i), src_sel, VEC[i][3:1]);
      chk($sformatf("R9 vector %0d err", i), cmd_err, VEC[i][0]);
    end
    chk("R11 run number latched", run_number, 32'hA5A5_0001);

    // R3 / R10: active marker and stalled command
    cmd_arg = 32'h0000_0042;
    step(1'b1, 4'd1, 1'b0);
    chk("R3 active pulse", mark_active, 1);
    chk("R3 ready low", cmd_ready, 0);
    cmd_valid = 1'b1; cmd_code = 4'd2; cmd_arg = 32'hDEAD_BEEF;
    @(negedge clk);
    chk("R10 not consumed", run_state, 1);
    chk("R10 no error", cmd_err, 0);
    chk("R3 single pulse", mark_active, 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R10 consumed late", run_state, 2);
    chk("R11 run number held", run_number, 32'h42);

    // R6 abort from sync
    step(1'b1, 4'd5, 1'b0);
    chk("R6 abort from sync", run_state, 0);

    // R6 abort collides with drain
    step(1'b1, 4'd1, 1'b0);
    step(1'b1, 4'd2, 1'b0);
    step(1'b1, 4'd3, 1'b0);
    step(1'b1, 4'd4, 1'b0);
    chk("R6 in terminating", run_state, 4);
    step(1'b1, 4'd5, 1'b1);
    chk("R6 abort wins", run_state, 0);
    chk("R6 no tail", mark_tail, 0);
    @(negedge clk);
    chk("R6 no late tail", mark_tail, 0);

    // R5 tail pulse timing, R8 reset from running
    step(1'b1, 4'd1, 1'b0);
    step(1'b1, 4'd2, 1'b0);
    step(1'b1, 4'd3, 1'b0);
    step(1'b1, 4'd4, 1'b0);
    step(1'b0, 4'd0, 1'b1);
    chk("R5 tail pulse", mark_tail, 1);
    chk("R5 state held", run_state, 4);
    @(negedge clk);
    chk("R5 tail single", mark_tail, 0);
    chk("R5 idle after tail", run_state, 0);
    step(1'b1, 4'd1, 1'b0);
    step(1'b1, 4'd2, 1'b0);
    step(1'b1, 4'd3, 1'b0);
    step(1'b1, 4'd10, 1'b0);
    chk("R8 reset from running", run_state, 7);
    step(1'b0, 4'd0, 1'b1);
    chk("R12 drain in reset", run_state, 7);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule